// File: doc/BRIEF.md
# Partitioned Final-OR Decision Logic

This block sits at the end of a trigger chain and turns, on every bunch crossing, a wide set of trigger bits into one accept request per data-acquisition partition. It takes 128 algorithm bits and 64 technical bits. The two sets are joined into one 192-bit trigger vector: algorithm bit k sits at index k and technical bit j at index 128+j. Each bit passes through its own prescaler, which lets one in N of its assertions through. Each bit also has its own saturating rate counter, which counts the raw bit before prescaling.

Each of the eight partitions has its own inclusion mask over the whole prescaled vector, so it ORs any subset of the bits. A partition also has a veto mask over the raw technical bits. Any enabled technical bit that is asserted suppresses that partition's accept in that crossing. The same technical bit can therefore serve as a trigger in one partition and as a veto in another, and the partitions run independently of each other.

A host reaches the prescale factors, the rate counters and both sets of masks through a flat write/read register port. A separate strobe clears all rate counters at once.

Top module: `partition_accept_or`

## Requirements
- R1: After reset every `part_accept` bit is 0, every rate counter reads 0, every prescale factor reads 1, and every inclusion and veto mask word reads 0.
- R2: `part_accept[p]` is registered. At the clock edge after a crossing is presented, it takes the OR over indices i of (prescaled bit i AND inclusion bit i of partition p), gated by the veto of R8.
- R3: A partition whose inclusion mask is all zero never raises its accept, whatever the inputs.
- R4: A prescale factor N >= 2 passes the Nth, 2Nth, ... assertion of its bit. Only cycles in which the bit is high advance the count. Writing the factor restarts the count, so the Nth assertion after the write is the first to pass.
- R5: A prescale factor of 1 passes every assertion, and a factor of 0 blocks the bit completely.
- R6: Each rate counter (16 bits) adds one for every cycle its raw bit is high. This holds regardless of prescale or masks. The counter stops at 65535 and does not wrap.
- R7: A high `cnt_clr` sets every rate counter to 0 at the next edge. The clear wins over an increment in the same cycle, and counting resumes afterwards.
- R8: If technical bit j is high in a crossing and veto bit j of partition p is set, then `part_accept[p]` is 0 for that crossing and other partitions are unaffected. A veto bit whose technical bit is low has no effect.
- R9: A technical bit included through inclusion index 128+j triggers a partition like any algorithm bit.
- R10: Register map. `reg_addr[10:8]` selects the region and `reg_addr[7:0]` is the index.
  - Region 0 holds the prescale factors. The index is the trigger index, the factor is in `reg_wdata[7:0]`, and reads return it zero-extended.
  - Region 1 holds the rate counters. It is read-only, writes to it are ignored, and reads return the count zero-extended.
  - Region 2 holds the inclusion mask words. The partition is `reg_addr[7:5]` and the word is `reg_addr[2:0]`, 0..5. Word w covers trigger indices 32w..32w+31, with bit b at index 32w+b.
  - Region 3 holds the veto mask words. The same fields are used with word 0..1, and word w covers technical bits 32w..32w+31.
  - Reads of any other region, trigger index or word return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| algo_bits | input | 128 | Algorithm bits of the current crossing |
| tech_bits | input | 64 | Technical bits of the current crossing |
| cnt_clr | input | 1 | Clears all rate counters |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 11 | Register address (region, index) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| part_accept | output | 8 | Registered accept request, one per partition |

## Verification
The assertions assume that a register write and a trigger crossing do not target the same bit's prescaler in one cycle. They also assume that masks are stable in the cycle whose accept they govern, so that the registered accept can be related to the previous cycle's masks and inputs. The directed stimulus therefore always writes configuration during idle crossings and presents trigger bits only between writes. Every crossing is a single-cycle pulse followed by at least one idle cycle, so each prescaler count step is tied to exactly one observed accept.

// File: rtl/fo_pkg.sv
package fo_pkg;

    localparam int ALGO_N  = 128;
    localparam int TECH_N  = 64;
    localparam int PART_N  = 8;
    localparam int PS_W    = 8;
    localparam int CNT_W   = 16;
    localparam int DATA_W  = 32;
    localparam int SEL_W   = 3;
    localparam int IDX_W   = 8;
    localparam int ADDR_W  = 3 + IDX_W;

    // region codes carried in reg_addr[10:8]
    typedef enum logic [2:0] {
        RG_PRESCALE = 3'd0,
        RG_RATE     = 3'd1,
        RG_INCL     = 3'd2,
        RG_VETO     = 3'd3
    } region_e;

    // view of the register address
    typedef struct packed {
        logic [2:0]       region;
        logic [SEL_W-1:0] part;
        logic [1:0]       spare;
        logic [SEL_W-1:0] word;
    } reg_addr_t;

    function automatic int words_for(input int bits);
        return (bits + DATA_W - 1) / DATA_W;
    endfunction

endpackage

// File: rtl/fo_bit_channel.sv
module fo_bit_channel #(
    parameter int PS_W  = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic             ps_we,
    input  logic [PS_W-1:0]  ps_wdata,
    input  logic             cnt_clr,
    output logic [PS_W-1:0]  factor_o,
    output logic [CNT_W-1:0] count_o,
    output logic             pass_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [PS_W-1:0]  ONE     = PS_W'(1);

    logic [PS_W-1:0]  factor_q;
    logic [PS_W-1:0]  seen_q;
    logic [CNT_W-1:0] count_q;
    logic             last_of_n;

    assign last_of_n = (seen_q == factor_q - ONE);
    assign pass_o    = bit_in && (factor_q != '0) && last_of_n;
    assign factor_o  = factor_q;
    assign count_o   = count_q;

    // prescaler: counts assertions, passes every factor-th one
    always_ff @(posedge clk) begin
        if (rst) begin
            factor_q <= ONE;
            seen_q   <= '0;
        end else if (ps_we) begin
            factor_q <= ps_wdata;
            seen_q   <= '0;
        end else if (bit_in && factor_q != '0) begin
            if (last_of_n) seen_q <= '0;
            else           seen_q <= seen_q + ONE;
        end
    end

    // raw rate counter, saturating
    always_ff @(posedge clk) begin
        if (rst || cnt_clr)
            count_q <= '0;
        else if (bit_in && count_q != CNT_MAX)
            count_q <= count_q + 1'b1;
    end

    p_sat_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (count_q == CNT_MAX && !cnt_clr) |=> (count_q == CNT_MAX));

    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_in && !cnt_clr && count_q != CNT_MAX) |=> (count_q == $past(count_q) + 1'b1));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (count_q == '0));

    p_seen_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (factor_q != '0) |-> (seen_q < factor_q));

    p_unit_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (factor_q == ONE && bit_in) |-> pass_o);

endmodule

// File: rtl/fo_mask_regs.sv
module fo_mask_regs
    import fo_pkg::*;
#(
    parameter int N_PART = 8,
    parameter int N_TRIG = 192,
    parameter int N_TECH = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          incl_we,
    input  logic                          veto_we,
    input  logic [SEL_W-1:0]              part_sel,
    input  logic [SEL_W-1:0]              word_sel,
    input  logic [DATA_W-1:0]             wdata,
    output logic [N_PART-1:0][N_TRIG-1:0] incl_o,
    output logic [N_PART-1:0][N_TECH-1:0] veto_o,
    output logic [DATA_W-1:0]             incl_rd,
    output logic [DATA_W-1:0]             veto_rd
);
    localparam int IW = words_for(N_TRIG);
    localparam int VW = words_for(N_TECH);

    logic [N_PART-1:0][IW*DATA_W-1:0] incl_q;
    logic [N_PART-1:0][VW*DATA_W-1:0] veto_q;
    logic part_ok, incl_ok, veto_ok;

    assign part_ok = int'(part_sel) < N_PART;
    assign incl_ok = part_ok && (int'(word_sel) < IW);
    assign veto_ok = part_ok && (int'(word_sel) < VW);

    always_ff @(posedge clk) begin
        if (rst) begin
            incl_q <= '0;
            veto_q <= '0;
        end else begin
            if (incl_we && incl_ok)
                incl_q[part_sel][int'(word_sel)*DATA_W +: DATA_W] <= wdata;
            if (veto_we && veto_ok)
                veto_q[part_sel][int'(word_sel)*DATA_W +: DATA_W] <= wdata;
        end
    end

    always_comb begin
        incl_rd = '0;
        veto_rd = '0;
        if (incl_ok) incl_rd = incl_q[part_sel][int'(word_sel)*DATA_W +: DATA_W];
        if (veto_ok) veto_rd = veto_q[part_sel][int'(word_sel)*DATA_W +: DATA_W];
    end

    for (genvar p = 0; p < N_PART; p++) begin : g_out
        assign incl_o[p] = incl_q[p][N_TRIG-1:0];
        assign veto_o[p] = veto_q[p][N_TECH-1:0];
    end

endmodule

// File: rtl/fo_part_or.sv
module fo_part_or #(
    parameter int N_TRIG = 192,
    parameter int N_TECH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TRIG-1:0] pass_vec,
    input  logic [N_TECH-1:0] tech_raw,
    input  logic [N_TRIG-1:0] incl,
    input  logic [N_TECH-1:0] veto,
    output logic              accept_q
);
    logic hit, blocked;

    assign hit     = |(pass_vec & incl);
    assign blocked = |(tech_raw & veto);

    always_ff @(posedge clk) begin
        if (rst) accept_q <= 1'b0;
        else     accept_q <= hit && !blocked;
    end

    p_veto_r8: assert property (@(posedge clk) disable iff (rst)
        (|(tech_raw & veto)) |=> !accept_q);

    p_empty_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (incl == '0) |=> !accept_q);

    p_no_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (pass_vec == '0) |=> !accept_q);

endmodule

// File: rtl/partition_accept_or.sv
module partition_accept_or
    import fo_pkg::*;
#(
    parameter int N_ALGO = ALGO_N,
    parameter int N_TECH = TECH_N,
    parameter int N_PART = PART_N,
    parameter int PSW    = PS_W,
    parameter int CW     = CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_ALGO-1:0]   algo_bits,
    input  logic [N_TECH-1:0]   tech_bits,
    input  logic                cnt_clr,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [N_PART-1:0]   part_accept
);
    localparam int N_TRIG = N_ALGO + N_TECH;

    reg_addr_t          ra;
    logic [IDX_W-1:0]   idx;
    logic               idx_ok;
    logic               wr_ps, wr_incl, wr_veto;
    logic [N_TRIG-1:0]  trig_vec, pass_vec, ps_we;
    logic [N_TRIG-1:0][PSW-1:0] factor_all;
    logic [N_TRIG-1:0][CW-1:0]  count_all;
    logic [N_PART-1:0][N_TRIG-1:0] incl_m;
    logic [N_PART-1:0][N_TECH-1:0] veto_m;
    logic [DATA_W-1:0]  incl_rd, veto_rd;
    logic [1:0]         unused_spare;

    assign ra           = reg_addr_t'(reg_addr);
    assign idx          = reg_addr[IDX_W-1:0];
    assign idx_ok       = int'(idx) < N_TRIG;
    assign unused_spare = ra.spare;
    assign trig_vec     = {tech_bits, algo_bits};

    assign wr_ps   = reg_we && (ra.region == RG_PRESCALE);
    assign wr_incl = reg_we && (ra.region == RG_INCL);
    assign wr_veto = reg_we && (ra.region == RG_VETO);

    for (genvar i = 0; i < N_TRIG; i++) begin : g_bit
        assign ps_we[i] = wr_ps && (int'(idx) == i);
        fo_bit_channel #(.PS_W(PSW), .CNT_W(CW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .bit_in   (trig_vec[i]),
            .ps_we    (ps_we[i]),
            .ps_wdata (reg_wdata[PSW-1:0]),
            .cnt_clr  (cnt_clr),
            .factor_o (factor_all[i]),
            .count_o  (count_all[i]),
            .pass_o   (pass_vec[i])
        );
    end

    fo_mask_regs #(.N_PART(N_PART), .N_TRIG(N_TRIG), .N_TECH(N_TECH)) u_masks (
        .clk      (clk),
        .rst      (rst),
        .incl_we  (wr_incl),
        .veto_we  (wr_veto),
        .part_sel (ra.part),
        .word_sel (ra.word),
        .wdata    (reg_wdata),
        .incl_o   (incl_m),
        .veto_o   (veto_m),
        .incl_rd  (incl_rd),
        .veto_rd  (veto_rd)
    );

    for (genvar p = 0; p < N_PART; p++) begin : g_part
        fo_part_or #(.N_TRIG(N_TRIG), .N_TECH(N_TECH)) u_or (
            .clk      (clk),
            .rst      (rst),
            .pass_vec (pass_vec),
            .tech_raw (tech_bits),
            .incl     (incl_m[p]),
            .veto     (veto_m[p]),
            .accept_q (part_accept[p])
        );
    end

    always_comb begin
        reg_rdata = '0;
        case (ra.region)
            RG_PRESCALE: if (idx_ok) reg_rdata = DATA_W'(factor_all[idx]);
            RG_RATE:     if (idx_ok) reg_rdata = DATA_W'(count_all[idx]);
            RG_INCL:     reg_rdata = incl_rd;
            RG_VETO:     reg_rdata = veto_rd;
            default:     reg_rdata = '0;
        endcase
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (part_accept == '0));

    p_accept_needs_input_r2: assert property (@(posedge clk) disable iff (rst)
        (trig_vec == '0) |=> (part_accept == '0));

endmodule

// File: tb/tb_partition_accept_or.sv
`timescale 1ns/1ps
module tb_partition_accept_or;
    logic         clk = 1'b0;
    logic         rst;
    logic [127:0] algo_bits;
    logic [63:0]  tech_bits;
    logic         cnt_clr;
    logic         reg_we;
    logic [10:0]  reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic [7:0]   part_accept;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #10 clk = ~clk;

    partition_accept_or dut (
        .clk(clk), .rst(rst), .algo_bits(algo_bits), .tech_bits(tech_bits),
        .cnt_clr(cnt_clr), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .part_accept(part_accept)
    );

    function automatic logic [10:0] a_ps(input int i);
        return {3'd0, 8'(i)};
    endfunction
    function automatic logic [10:0] a_rt(input int i);
        return {3'd1, 8'(i)};
    endfunction
    function automatic logic [10:0] a_in(input int p, input int w);
        return {3'd2, 3'(p), 2'b00, 3'(w)};
    endfunction
    function automatic logic [10:0] a_vt(input int p, input int w);
        return {3'd3, 3'(p), 2'b00, 3'(w)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #2 d = reg_rdata;
    endtask

    task automatic xing(input logic [127:0] a, input logic [63:0] t, output logic [7:0] acc);
        @(negedge clk);
        algo_bits = a; tech_bits = t;
        @(negedge clk);
        acc = part_accept;
        algo_bits = '0; tech_bits = '0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
    endtask

    function automatic logic [127:0] ab(input int k);
        return 128'(1) << k;
    endfunction
    function automatic logic [63:0] tb_(input int k);
        return 64'(1) << k;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 accept after reset", 32'(part_accept), 32'h0);
        rd(a_ps(0), d);   chk("R1 prescale idx0", d, 32'h1);
        rd(a_ps(191), d); chk("R1 prescale idx191", d, 32'h1);
        rd(a_rt(7), d);   chk("R1 rate idx7", d, 32'h0);
        rd(a_in(3, 2), d); chk("R1 incl word", d, 32'h0);
        rd(a_vt(5, 1), d); chk("R1 veto word", d, 32'h0);
    endtask

    task automatic t_empty_mask();
        logic [7:0] acc;
        xing('1, '0, acc);
        chk("R3 all algo bits, empty masks", 32'(acc), 32'h0);
        xing('1, '1, acc);
        chk("R3 all bits, empty masks", 32'(acc), 32'h0);
    endtask

    task automatic t_basic_or();
        logic [7:0] acc;
        wr(a_in(0, 0), 32'h0000_0008);
        wr(a_in(1, 3), 32'h8000_0000);
        xing(ab(3), '0, acc);            chk("R2 algo3 -> p0", 32'(acc), 32'h01);
        xing(ab(127), '0, acc);          chk("R2 algo127 -> p1", 32'(acc), 32'h02);
        xing(ab(3) | ab(127), '0, acc);  chk("R2 both -> p0,p1", 32'(acc), 32'h03);
        xing(ab(4), '0, acc);            chk("R2 unmasked bit", 32'(acc), 32'h00);
        @(negedge clk); algo_bits = ab(3);
        #2 chk("R2 no same-cycle accept", 32'(part_accept), 32'h00);
        @(negedge clk); algo_bits = '0;
        chk("R2 accept one edge later", 32'(part_accept), 32'h01);
        @(negedge clk);
    endtask

    task automatic t_tech_trig();
        logic [7:0] acc;
        wr(a_in(2, 4), 32'h0000_0001);
        xing('0, tb_(0), acc);   chk("R9 tech0 triggers p2", 32'(acc), 32'h04);
        xing('0, tb_(1), acc);   chk("R9 tech1 not included", 32'(acc), 32'h00);
    endtask

    task automatic t_veto();
        logic [7:0] acc;
        wr(a_vt(0, 0), 32'h0000_0020);
        xing(ab(3) | ab(127), tb_(5), acc);
        chk("R8 tech5 vetoes p0 only", 32'(acc), 32'h02);
        xing(ab(3), '0, acc);
        chk("R8 veto idle when tech5 low", 32'(acc), 32'h01);
        xing(ab(3), tb_(6), acc);
        chk("R8 non-veto tech bit", 32'(acc), 32'h01);
    endtask

    task automatic t_prescale();
        logic [7:0] acc;
        logic [7:0] exp_seq [6] = '{8'h0, 8'h0, 8'h1, 8'h0, 8'h0, 8'h1};
        wr(a_ps(3), 32'd3);
        for (int k = 0; k < 6; k++) begin
            xing(ab(3), '0, acc);
            chk($sformatf("R4 factor3 assertion %0d", k + 1), 32'(acc), 32'(exp_seq[k]));
            @(negedge clk);
        end
        xing(ab(3), '0, acc);
        chk("R4 before restart", 32'(acc), 32'h0);
        wr(a_ps(3), 32'd3);
        xing(ab(3), '0, acc); chk("R4 restart 1", 32'(acc), 32'h0);
        xing(ab(3), '0, acc); chk("R4 restart 2", 32'(acc), 32'h0);
        xing(ab(3), '0, acc); chk("R4 restart 3 passes", 32'(acc), 32'h1);
    endtask

    task automatic t_factor_0_1();
        logic [7:0] acc;
        wr(a_ps(3), 32'd0);
        for (int k = 0; k < 3; k++) begin
            xing(ab(3), '0, acc);
            chk("R5 factor0 blocks", 32'(acc), 32'h0);
        end
        wr(a_ps(3), 32'd1);
        for (int k = 0; k < 3; k++) begin
            xing(ab(3), '0, acc);
            chk("R5 factor1 passes all", 32'(acc), 32'h1);
        end
    endtask

    task automatic t_rate();
        logic [7:0]  acc;
        logic [31:0] d;
        wr(a_ps(10), 32'd0);
        pulse_clear();
        for (int k = 0; k < 4; k++) xing(ab(10), '0, acc);
        for (int k = 0; k < 2; k++) xing('0, tb_(7), acc);
        rd(a_rt(10), d);  chk("R6 raw count algo10 despite factor0", d, 32'd4);
        rd(a_rt(135), d); chk("R6 raw count tech7", d, 32'd2);
        wr(a_rt(10), 32'd99);
        rd(a_rt(10), d);  chk("R10 rate write ignored", d, 32'd4);
        @(negedge clk); algo_bits = ab(20);
        repeat (70000) @(negedge clk);
        algo_bits = '0;
        rd(a_rt(20), d);  chk("R6 saturates", d, 32'd65535);
    endtask

    task automatic t_clear();
        logic [7:0]  acc;
        logic [31:0] d;
        @(negedge clk); algo_bits = ab(20); cnt_clr = 1'b1;
        @(negedge clk); algo_bits = '0;     cnt_clr = 1'b0;
        rd(a_rt(20), d);  chk("R7 clear wins over increment", d, 32'd0);
        rd(a_rt(10), d);  chk("R7 clear all counters", d, 32'd0);
        xing(ab(20), '0, acc);
        rd(a_rt(20), d);  chk("R7 count resumes", d, 32'd1);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(a_ps(50), 32'hFFFF_FFA5);
        rd(a_ps(50), d);   chk("R10 prescale 8-bit field", d, 32'h0000_00A5);
        rd(a_in(1, 3), d); chk("R10 incl readback", d, 32'h8000_0000);
        rd(a_vt(0, 0), d); chk("R10 veto readback", d, 32'h0000_0020);
        rd(a_in(1, 6), d); chk("R10 incl word beyond range", d, 32'h0);
        rd({3'd5, 8'd3}, d); chk("R10 unmapped region", d, 32'h0);
        rd(a_ps(200), d);  chk("R10 index beyond range", d, 32'h0);
    endtask

    initial begin
        rst = 1'b1; algo_bits = '0; tech_bits = '0; cnt_clr = 1'b0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_empty_mask();
        t_basic_or();
        t_tech_trig();
        t_veto();
        t_prescale();
        t_factor_0_1();
        t_rate();
        t_clear();
        t_map();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule